// File: doc/BRIEF.md
# One-Wire Identity Search Master

This block enumerates every slave on a shared, open-drain one-wire bus by walking the binary tree formed by their 64-bit identities. It has no timing of its own on the bus. It drives a separate bit-slot engine through a small request interface with three kinds of operation: a bus reset that returns whether any slave answered, a single-bit write, and a single-bit read that returns the wired-AND of all slaves still taking part. Each operation stays requested until the engine acknowledges it.

After a `start` pulse the block runs search passes. Each pass is a bus reset, the 8-bit search command, and then one triplet per identity bit. A triplet is a read of the true bit, a read of the complement bit and a write of the chosen direction. A pass finds exactly one identity, which is presented for one cycle on `id_value` with `id_valid`. The direction taken where slaves disagree comes from the two reads together with the deepest position at which the previous pass chose 0. Because of this, later passes visit the branches not yet explored. `done` rises once a pass ends without choosing 0 at any disagreement. `error` rises when a bit position has no slave answering.

The controller is one state machine with states IDLE, RESET, CMD, RD_TRUE, RD_COMP, WRITE and EMIT. Its transitions are:
- IDLE→RESET on `start`.
- RESET→CMD on an acknowledged reset with presence.
- RESET→IDLE on an acknowledged reset without presence, which sets `done`.
- CMD→CMD while command bits remain, then CMD→RD_TRUE after the eighth bit.
- RD_TRUE→RD_COMP on acknowledge.
- RD_COMP→WRITE on acknowledge.
- RD_COMP→IDLE when both reads are 1, which sets `error`.
- WRITE→RD_TRUE for the next bit, or WRITE→EMIT after the last bit.
- EMIT→RESET when the pass chose 0 at some disagreement.
- EMIT→IDLE when it did not, which sets `done`.

Top module: `ows_master`

## Requirements
- R1: After reset `op_req`, `id_valid`, `done` and `error` are all 0, and nothing is requested until `start`.
- R2: Every pass starts with a reset request (`op_code` 0). If presence is reported (`op_rbit`=1 on its acknowledge), eight write requests (`op_code` 1) follow, carrying the byte F0h least significant bit first.
- R3: After the command, each identity bit, from bit 0 up to bit 63, is handled by two read requests (`op_code` 2) followed by one write. A request and its `op_code` and `op_wdata` stay stable until `op_ack`.
- R4: When the true and complement reads differ, the value written is the true-bit value.
- R5: When both reads are 0 at 1-based position p, the value written is chosen from L, the last 0-choice position of the previous pass (0 for the first pass). It is 1 if p equals L, the previous identity's bit if p is less than L, and 0 if p is greater than L. The largest position where 0 was chosen in the current pass becomes L for the next pass.
- R6: Each completed pass gives one single-cycle `id_valid` pulse with the identity written during that pass (bit i is the i-th triplet's write). Across a run every slave is reported exactly once, in ascending order of the bit-reversed identity.
- R7: When a pass ends with no 0-choice recorded, `done` goes to 1 and stays there, with no further requests, until the next `start`. `start` clears `done` and `error`.
- R8: If both reads of a triplet return 1, the pass stops with no write and no `id_valid`, and `error` rises while `done` stays 0.
- R9: If a reset request returns no presence, the run ends at once with `done`=1 and no identity reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an enumeration run (taken in IDLE) |
| op_req | output | 1 | Operation requested from the bit-slot engine |
| op_code | output | 2 | 0 reset, 1 write bit, 2 read bit |
| op_wdata | output | 1 | Bit value for a write request |
| op_ack | input | 1 | One-cycle completion of the current request |
| op_rbit | input | 1 | Read value, or presence for a reset, valid with `op_ack` |
| id_valid | output | 1 | One-cycle strobe: `id_value` holds a found identity |
| id_value | output | 64 | Identity found in the last pass |
| done | output | 1 | Enumeration finished (held until next start) |
| error | output | 1 | A bit position had no responding slave |

## Verification
The hardest path to reach is a pass where the branch chosen depends on the previous identity's bit below the last 0-choice position. That needs at least three slaves whose identities share some low bits and split at several depths. The stimulus table holds slave sets of this kind. This includes identities that differ only at bit 0 and bit 63, and a set where one subtree forks twice. The bench slave model reproduces the wired-AND for these sets, so the order in which identities come out checks the branch rule across passes. A second case that cannot be reached with well-behaved slaves is a triplet where both reads return 1. The bench model has a mode in which slaves answer presence but then never pull the line low, and this forces that case.

// File: rtl/ows_pkg.sv
package ows_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RESET,
        S_CMD,
        S_RD_TRUE,
        S_RD_COMP,
        S_WRITE,
        S_EMIT
    } state_e;

endpackage

// File: rtl/ows_branch.sv
module ows_branch #(
    parameter int PW = 7
) (
    input  logic          t_bit,
    input  logic          c_bit,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] last_disc,
    input  logic          prev_bit,
    output logic          dir,
    output logic          zero_pick,
    output logic          conflict
);

    always_comb begin
        conflict  = t_bit & c_bit;
        zero_pick = 1'b0;
        dir       = t_bit;
        if (!t_bit && !c_bit) begin
            if (pos == last_disc) begin
                dir = 1'b1;
            end else if (pos < last_disc) begin
                dir = prev_bit;
            end else begin
                dir = 1'b0;
            end
            zero_pick = ~dir;
        end
    end

endmodule

// File: rtl/ows_idstore.sv
module ows_idstore #(
    parameter int ID_W = 64,
    parameter int IW   = 6,
    parameter int PW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic            pass_start,
    input  logic            bit_we,
    input  logic [IW-1:0]   bit_idx,
    input  logic            bit_val,
    input  logic            mark,
    input  logic [PW-1:0]   pos,
    input  logic            pass_end,
    output logic [ID_W-1:0] cur_id,
    output logic            prev_bit,
    output logic [PW-1:0]   last_disc,
    output logic [PW-1:0]   pass_disc
);

    logic [ID_W-1:0] prev_id;

    for (genvar g = 0; g < ID_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_id[g] <= 1'b0;
            end else if (bit_we && (bit_idx == IW'(g))) begin
                cur_id[g] <= bit_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_id   <= '0;
            last_disc <= '0;
            pass_disc <= '0;
        end else begin
            if (clr_all) begin
                prev_id   <= '0;
                last_disc <= '0;
            end else if (pass_end) begin
                prev_id   <= cur_id;
                last_disc <= pass_disc;
            end
            if (pass_start) begin
                pass_disc <= '0;
            end else if (mark) begin
                pass_disc <= pos;
            end
        end
    end

    assign prev_bit = prev_id[bit_idx];

    p_disc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_disc <= PW'(ID_W)) && (last_disc <= PW'(ID_W)));

endmodule

// File: rtl/ows_master.sv
module ows_master
    import ows_pkg::*;
#(
    parameter int ID_W = 64,
    parameter int CMD_W = 8,
    parameter logic [CMD_W-1:0] SEARCH_CMD = 8'hF0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            op_req,
    output logic [1:0]      op_code,
    output logic            op_wdata,
    input  logic            op_ack,
    input  logic            op_rbit,
    output logic            id_valid,
    output logic [ID_W-1:0] id_value,
    output logic            done,
    output logic            error
);

    localparam int IW = $clog2(ID_W);
    localparam int PW = $clog2(ID_W + 1);
    localparam int CW = $clog2(CMD_W);

    state_e          state, nxt;
    logic [IW-1:0]   bit_idx;
    logic [CW-1:0]   cmd_idx;
    logic            t_bit, dir_r;
    logic            done_r, err_r;
    logic [PW-1:0]   pos;
    logic            br_dir, br_zero, br_conflict;
    logic            st_prev_bit;
    logic [PW-1:0]   st_last_disc, st_pass_disc;
    logic [ID_W-1:0] st_id;
    logic            last_bit, last_cmd;
    logic            clr_all, pass_start, mark, bit_we, pass_end;
    op_e             code;

    assign pos      = PW'(bit_idx) + PW'(1);
    assign last_bit = (bit_idx == IW'(ID_W - 1));
    assign last_cmd = (cmd_idx == CW'(CMD_W - 1));

    assign clr_all    = (state == S_IDLE) && start;
    assign pass_start = (state == S_RESET) && op_ack;
    assign mark       = (state == S_RD_COMP) && op_ack && br_zero;
    assign bit_we     = (state == S_WRITE) && op_ack;
    assign pass_end   = (state == S_EMIT);

    ows_branch #(.PW(PW)) u_branch (
        .t_bit     (t_bit),
        .c_bit     (op_rbit),
        .pos       (pos),
        .last_disc (st_last_disc),
        .prev_bit  (st_prev_bit),
        .dir       (br_dir),
        .zero_pick (br_zero),
        .conflict  (br_conflict)
    );

    ows_idstore #(.ID_W(ID_W), .IW(IW), .PW(PW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (clr_all),
        .pass_start (pass_start),
        .bit_we     (bit_we),
        .bit_idx    (bit_idx),
        .bit_val    (dir_r),
        .mark       (mark),
        .pos        (pos),
        .pass_end   (pass_end),
        .cur_id     (st_id),
        .prev_bit   (st_prev_bit),
        .last_disc  (st_last_disc),
        .pass_disc  (st_pass_disc)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start) nxt = S_RESET;
            S_RESET:   if (op_ack) nxt = op_rbit ? S_CMD : S_IDLE;
            S_CMD:     if (op_ack && last_cmd) nxt = S_RD_TRUE;
            S_RD_TRUE: if (op_ack) nxt = S_RD_COMP;
            S_RD_COMP: if (op_ack) nxt = br_conflict ? S_IDLE : S_WRITE;
            S_WRITE:   if (op_ack) nxt = last_bit ? S_EMIT : S_RD_TRUE;
            S_EMIT:    nxt = (st_pass_disc == '0) ? S_IDLE : S_RESET;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            cmd_idx <= '0;
            t_bit   <= 1'b0;
            dir_r   <= 1'b0;
            done_r  <= 1'b0;
            err_r   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    done_r <= 1'b0;
                    err_r  <= 1'b0;
                end
                S_RESET: if (op_ack) begin
                    cmd_idx <= '0;
                    bit_idx <= '0;
                    if (!op_rbit) done_r <= 1'b1;
                end
                S_CMD:     if (op_ack) cmd_idx <= cmd_idx + CW'(1);
                S_RD_TRUE: if (op_ack) t_bit <= op_rbit;
                S_RD_COMP: if (op_ack) begin
                    dir_r <= br_dir;
                    if (br_conflict) err_r <= 1'b1;
                end
                S_WRITE:   if (op_ack && !last_bit) bit_idx <= bit_idx + IW'(1);
                S_EMIT:    if (st_pass_disc == '0) done_r <= 1'b1;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        op_req   = 1'b0;
        code     = OP_RESET;
        op_wdata = 1'b0;
        id_valid = 1'b0;
        unique case (state)
            S_RESET:   op_req = 1'b1;
            S_CMD: begin
                op_req   = 1'b1;
                code     = OP_WRITE;
                op_wdata = SEARCH_CMD[cmd_idx];
            end
            S_RD_TRUE, S_RD_COMP: begin
                op_req = 1'b1;
                code   = OP_READ;
            end
            S_WRITE: begin
                op_req   = 1'b1;
                code     = OP_WRITE;
                op_wdata = dir_r;
            end
            S_EMIT:    id_valid = 1'b1;
            default:   ;
        endcase
    end

    assign op_code  = code;
    assign id_value = st_id;
    assign done     = done_r;
    assign error    = err_r;

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ack) |=> (op_req && $stable(op_code) && $stable(op_wdata)));

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> !id_valid);

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!op_req && !id_valid));

    p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_RD_COMP) && op_ack && op_rbit && t_bit) |=> (error && !op_req && !done));

endmodule

// File: tb/sim_ows_master.sv
`timescale 1ns/1ps
module sim_ows_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_req;
    logic [1:0]  op_code;
    logic        op_wdata;
    logic        op_ack = 1'b0;
    logic        op_rbit = 1'b0;
    logic        id_valid;
    logic [63:0] id_value;
    logic        done;
    logic        error;

    always #4 clk = ~clk;

    ows_master u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_req(op_req), .op_code(op_code), .op_wdata(op_wdata),
        .op_ack(op_ack), .op_rbit(op_rbit),
        .id_valid(id_valid), .id_value(id_value),
        .done(done), .error(error)
    );

    // stimulus table: slave count and identities per scenario
    localparam int NSCN = 4;
    localparam int NSL_T [NSCN] = '{1, 3, 4, 2};
    localparam logic [63:0] IDS_T [NSCN][4] = '{
        '{64'h1D00_0012_3456_7828, 64'h0, 64'h0, 64'h0},
        '{64'h2D00_0000_00AB_CD2D, 64'h2D00_0000_00AB_CD2C, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0},
        '{64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001},
        '{64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 64'h0}
    };

    int          checks = 0;
    int          errors = 0;

    // slave population, set by the initial block
    int          nsl = 0;
    logic        ghost = 1'b0;
    logic [63:0] sid [4];

    // model state, written only by the model
    logic        active [4];
    int          phase = 0;
    int          cmdcnt = 0;
    logic [7:0]  cmdsh = '0;
    int          sidx = 0;
    int          sub = 0;
    int          n_resets = 0;
    int          cmd_bad = 0;
    int          proto_bad = 0;
    int          nfound = 0;
    logic [63:0] found [16];
    int          cnt = 0;
    logic [1:0]  lat_code = '0;
    logic        lat_wd = 1'b0;

    // bit-slot engine and wired-AND slave model, driven away from the active edge
    always @(negedge clk) begin
        logic r;
        if (id_valid) begin
            if (nfound < 16) found[nfound] = id_value;
            nfound = nfound + 1;
        end
        if (op_ack) begin
            op_ack = 1'b0;
        end else if (cnt == 0 && op_req && rst_n) begin
            lat_code = op_code;
            lat_wd   = op_wdata;
            cnt      = 2;
        end else if (cnt == 1) begin
            cnt = 0;
            r = 1'b0;
            case (lat_code)
                2'd0: begin
                    for (int k = 0; k < 4; k++) active[k] = (k < nsl);
                    phase = 0; cmdcnt = 0; cmdsh = '0; sidx = 0; sub = 0;
                    n_resets = n_resets + 1;
                    r = (nsl > 0);
                end
                2'd1: begin
                    if (phase == 0) begin
                        cmdsh[cmdcnt] = lat_wd;
                        cmdcnt = cmdcnt + 1;
                        if (cmdcnt == 8) begin
                            if (cmdsh != 8'hF0) cmd_bad = cmd_bad + 1;
                            phase = 1;
                        end
                    end else begin
                        if (sub != 2 || sidx > 63) proto_bad = proto_bad + 1;
                        else begin
                            for (int k = 0; k < 4; k++)
                                if (active[k] && sid[k][sidx] != lat_wd) active[k] = 1'b0;
                            sidx = sidx + 1;
                        end
                        sub = 0;
                    end
                end
                default: begin
                    if (phase == 0 || sub == 2 || sidx > 63) begin
                        proto_bad = proto_bad + 1;
                        r = 1'b1;
                    end else begin
                        r = 1'b1;
                        for (int k = 0; k < 4; k++)
                            if (active[k]) r = r & (sub == 0 ? sid[k][sidx] : ~sid[k][sidx]);
                        sub = sub + 1;
                    end
                    if (ghost) r = 1'b1;
                end
            endcase
            op_rbit = r;
            op_ack  = 1'b1;
        end else if (cnt > 1) begin
            cnt = cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rev64(input logic [63:0] v);
        logic [63:0] o;
        for (int i = 0; i < 64; i++) o[i] = v[63 - i];
        return o;
    endfunction

    // pulse start and wait for the run to end
    task automatic run_once(output bit timed_out);
        int t;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!(done || error) && t < 30000) begin
            @(negedge clk);
            t = t + 1;
        end
        timed_out = (t >= 30000);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_scn(input int s);
        int          base, rb, cb, pb, n;
        bit          to;
        logic [63:0] ex [4];
        logic [63:0] tmp;
        nsl = NSL_T[s];
        for (int k = 0; k < 4; k++) sid[k] = IDS_T[s][k];
        n = NSL_T[s];
        for (int k = 0; k < 4; k++) ex[k] = IDS_T[s][k];
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n - 1 - i; j++)
                if (rev64(ex[j]) > rev64(ex[j + 1])) begin
                    tmp = ex[j]; ex[j] = ex[j + 1]; ex[j + 1] = tmp;
                end
        base = nfound; rb = n_resets; cb = cmd_bad; pb = proto_bad;
        run_once(to);
        chk(!to, "R7", "run finished", 64'(to), 64'd0);
        chk(done && !error, "R7", "done set, error clear", {62'd0, done, error}, 64'd2);
        chk(nfound - base == n, "R6", "identities reported", 64'(nfound - base), 64'(n));
        chk(n_resets - rb == n, "R2", "one reset per pass", 64'(n_resets - rb), 64'(n));
        chk(cmd_bad == cb, "R2", "search command F0h lsb first", 64'(cmd_bad - cb), 64'd0);
        chk(proto_bad == pb, "R3", "read-read-write triplet order", 64'(proto_bad - pb), 64'd0);
        for (int k = 0; k < n && k < nfound - base; k++)
            chk(found[base + k] == ex[k], "R5", "identity in tree order (R4 R6)", found[base + k], ex[k]);
    endtask

    initial begin
        bit to;
        int base, rb;
        for (int k = 0; k < 4; k++) sid[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!op_req && !id_valid && !done && !error, "R1", "reset outputs",
            {60'd0, op_req, id_valid, done, error}, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!op_req, "R1", "no request before start", 64'(op_req), 64'd0);

        for (int s = 0; s < NSCN; s++) run_scn(s);

        // R7: done holds with no activity
        repeat (20) @(negedge clk);
        chk(done && !op_req, "R7", "done held, bus quiet", {62'd0, done, op_req}, 64'd2);

        // R9: empty bus
        nsl = 0;
        base = nfound; rb = n_resets;
        run_once(to);
        chk(done && !error, "R9", "empty bus ends done", {62'd0, done, error}, 64'd2);
        chk(nfound == base, "R9", "no identity on empty bus", 64'(nfound - base), 64'd0);
        chk(n_resets - rb == 1, "R9", "single reset", 64'(n_resets - rb), 64'd1);

        // R8: presence but no slave drives any read slot
        nsl = 1; sid[0] = 64'h0123_4567_89AB_CDEF; ghost = 1'b1;
        base = nfound;
        run_once(to);
        chk(error && !done, "R8", "error on both reads high", {62'd0, error, done}, 64'd2);
        chk(nfound == base, "R8", "no identity on error", 64'(nfound - base), 64'd0);
        repeat (10) @(negedge clk);
        chk(!op_req, "R8", "bus quiet after error", 64'(op_req), 64'd0);
        ghost = 1'b0;

        // R7: start clears flags and a new run succeeds
        run_scn(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
        $finish;
    end

endmodule